// File: doc/BRIEF.md
# Multi-channel compare timer bank

A bank of independent up-counting timer channels behind a small register bus. Each channel owns a counter, a compare value, a control word with an enable, a self-clearing reset bit and a two-bit operating mode, and a clock word that picks one of two tick sources and an optional divide-by-two. A compare hit can stop the channel (one-shot), reload it to zero (repeat), or be suppressed entirely (free-running, for a monotonic time base).

Two shared registers at the bottom of the map hold a per-channel interrupt mask and a write-one-to-clear acknowledge. Events are latched as pending flags whether or not they are masked, and one combined interrupt line reports any unmasked pending flag. The two tick inputs are single-cycle enables in the bus clock domain that stand in for the fast and slow reference clocks.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every channel is disabled with counter, compare, mode, source and divider at 0, the interrupt mask and all pending flags are 0, and `irq_o` is low.
- R2: Address bits [7:4] select a block: block 0 holds the mask at offset 0x00 (bit n-1 for channel n) and the acknowledge/pending register at 0x08; block n (1..6) holds control at +0x0, clock at +0x4, counter at +0x8, compare at +0xC. Reads of any other block return 0.
- R3: While enabled, a channel counter advances by exactly 1 on each effective tick and holds when disabled; writes to the counter register are ignored.
- R4: Clock bit 4 selects the tick source (0 = `fast_tick_i`, 1 = `slow_tick_i`); clock bit 0 set makes the channel count on every second selected tick, otherwise on every tick.
- R5: In mode 0 (control bits [5:4] = 0), on the tick where the counter reaches the compare value the pending flag sets, the enable bit (control bit 0) clears and the counter holds at the compare value.
- R6: In mode 1, on the tick where the counter reaches the compare value the pending flag sets and the counter reloads to 0 and keeps counting, giving a period of compare-value ticks.
- R7: In mode 3 (and the unused code 2) the counter wraps from all ones to 0 and never sets the pending flag.
- R8: Writing control bit 1 set zeroes the counter on that write's clock edge, taking priority over a tick; the bit always reads back 0, and when written with bit 0 set counting restarts from 0 on the following tick.
- R9: Writing the acknowledge register clears the pending flag of each channel whose bit is 1 and leaves the others; an event in the same cycle as its acknowledge leaves the flag set. Reading that offset returns the pending flags.
- R10: `irq_o` is high exactly while some channel has both its pending flag and its mask bit set; pending flags set regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_tick_i | input | 1 | Tick enable of the fast reference |
| slow_tick_i | input | 1 | Tick enable of the slow reference |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address while `req_i` is high |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every cycle the assertions check that a disabled counter holds, that a one-shot hit drops the enable and freezes the count, that a repeat hit reloads zero, that the free-running mode never raises an event, that a clear zeroes the counter and reads back 0, that the divide-by-two never steps on adjacent cycles, and that pending flags set on events, survive unrelated acknowledges and clear on their own. Only the bench scenarios can show the exact tick on which each hit lands for a given compare value and divider, the wrap of the full counter range, the address decode and the ignored counter writes, and the combined line following mask changes.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } gpt_mode_e;

  // register offsets inside a 16-byte block (addr[3:2])
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_CLK  = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;
  localparam logic [1:0] OFS_CMP  = 2'd3;
  localparam logic [1:0] GLB_IEN  = 2'd0;
  localparam logic [1:0] GLB_ACK  = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_DIV_BIT   = 0;
  localparam int CLK_SRC_BIT   = 4;
endpackage

// File: rtl/gpt_tick_sel.sv
module gpt_tick_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  input  logic src_i,
  input  logic div_i,
  input  logic run_i,
  input  logic restart_i,
  output logic step_o
);
  logic raw_tick;
  logic phase_q;

  assign raw_tick = src_i ? slow_tick_i : fast_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= 1'b0;
    else if (!run_i || restart_i) phase_q <= 1'b0;
    else if (raw_tick && div_i)  phase_q <= ~phase_q;
  end

  assign step_o = run_i && !restart_i && raw_tick && (!div_i || phase_q);

  // R4
  div_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && step_o) |=> !(div_i && step_o));
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             ctrl_we_i,
  input  logic             clk_we_i,
  input  logic             cmp_we_i,
  input  logic [31:0]      wdata_i,
  output logic             en_o,
  output logic [1:0]       mode_o,
  output logic             src_o,
  output logic             div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             evt_o
);
  logic             en_q, src_q, div_q;
  gpt_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_inc;
  logic             clear, step, compares, hit;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign clear    = ctrl_we_i && wdata_i[CTRL_CLR_BIT];
  assign cnt_inc  = cnt_q + 1'b1;
  assign compares = (mode_q == MODE_ONCE) || (mode_q == MODE_REPEAT);
  assign hit      = step && compares && (cnt_inc == cmp_q);

  gpt_tick_sel u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fast_tick_i(fast_tick_i),
    .slow_tick_i(slow_tick_i),
    .src_i      (src_q),
    .div_i      (div_q),
    .run_i      (en_q),
    .restart_i  (clear),
    .step_o     (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
      src_q  <= 1'b0;
      div_q  <= 1'b0;
      cmp_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= wdata_i[CTRL_EN_BIT];
        mode_q <= gpt_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
      end else if (hit && mode_q == MODE_ONCE) begin
        en_q <= 1'b0;
      end
      if (clk_we_i) begin
        src_q <= wdata_i[CLK_SRC_BIT];
        div_q <= wdata_i[CLK_DIV_BIT];
      end
      if (cmp_we_i) cmp_q <= wdata_i[CNT_W-1:0];
      if (clear)                              cnt_q <= '0;
      else if (hit && mode_q == MODE_REPEAT)  cnt_q <= '0;
      else if (step)                          cnt_q <= cnt_inc;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign src_o  = src_q;
  assign div_o  = div_q;
  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign evt_o  = hit;

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clear) |=> $stable(cnt_q));
  // R5
  once_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_q == MODE_ONCE && !ctrl_we_i && !cmp_we_i) |=> (!en_q && cnt_q == cmp_q));
  // R6
  repeat_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_q == MODE_REPEAT) |=> (cnt_q == '0));
  // R7
  free_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FREE || mode_q == MODE_RSVD) |-> !evt_o);
  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              ien_we_i,
  input  logic              ack_we_i,
  input  logic [31:0]       wdata_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, pend_q, ack_mask;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ack_mask = ack_we_i ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i[NUM_CH-1:0];
      pend_q <= (pend_q & ~ack_mask) | evt_i;
    end
  end

  assign ien_o  = ien_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ien_q);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R9
    ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_we_i && wdata_i[g] && !evt_i[g]) |=> !pend_q[g]);
    // R9
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !(ack_we_i && wdata_i[g])) |=> pend_q[g]);
    // R10
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> pend_q[g]);
  end
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        ofs;
  logic              wr, ien_we, ack_we;
  logic [NUM_CH-1:0] evt, ien, pend, en_a, src_a, div_a;
  logic [1:0]        mode_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [CNT_W-1:0]  cmp_a  [NUM_CH];
  logic [31:0]       rd;
  logic              unused_addr;

  assign blk         = addr_i[ADDR_W-1:4];
  assign ofs         = addr_i[3:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = req_i && we_i;
  assign ien_we      = wr && (blk == '0) && (ofs == GLB_IEN);
  assign ack_we      = wr && (blk == '0) && (ofs == GLB_ACK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr && (blk == BLK_W'(g + 1));
    gpt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fast_tick_i(fast_tick_i),
      .slow_tick_i(slow_tick_i),
      .ctrl_we_i  (sel && ofs == OFS_CTRL),
      .clk_we_i   (sel && ofs == OFS_CLK),
      .cmp_we_i   (sel && ofs == OFS_CMP),
      .wdata_i    (wdata_i),
      .en_o       (en_a[g]),
      .mode_o     (mode_a[g]),
      .src_o      (src_a[g]),
      .div_o      (div_a[g]),
      .cnt_o      (cnt_a[g]),
      .cmp_o      (cmp_a[g]),
      .evt_o      (evt[g])
    );
  end

  gpt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .ien_we_i(ien_we),
    .ack_we_i(ack_we),
    .wdata_i (wdata_i),
    .ien_o   (ien),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd = '0;
    if (blk == '0) begin
      if (ofs == GLB_IEN)      rd = 32'(ien);
      else if (ofs == GLB_ACK) rd = 32'(pend);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (blk == BLK_W'(i + 1)) begin
        case (ofs)
          OFS_CTRL: rd = {26'b0, mode_a[i], 3'b0, en_a[i]};
          OFS_CLK:  rd = {27'b0, src_a[i], 3'b0, div_a[i]};
          OFS_CNT:  rd = 32'(cnt_a[i]);
          default:  rd = 32'(cmp_a[i]);
        endcase
      end
    end
  end

  assign rdata_o = req_i ? rd : '0;

  // R8
  clr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && blk != '0 && ofs == OFS_CTRL) |-> !rdata_o[CTRL_CLR_BIT]);
endmodule

// File: tb/gp_timer_bank_tb_top.sv
`timescale 1ns/10ps
module gp_timer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b1;
  logic        slow_tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer_bank #(.NUM_CH(6), .CNT_W(8), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] a_ctrl(int ch); return 8'(16 * ch);      endfunction
  function automatic logic [7:0] a_clk (int ch); return 8'(16 * ch + 4);  endfunction
  function automatic logic [7:0] a_cnt (int ch); return 8'(16 * ch + 8);  endfunction
  function automatic logic [7:0] a_cmp (int ch); return 8'(16 * ch + 12); endfunction
  function automatic int hit_delay(int cmp, int div); return cmp * (div + 1); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; consumes exactly one rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #0.2;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic chk_rd(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1c0ffee));
    waitn(2);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    chk_rd("R1 mask", 8'h00, 32'h0);
    chk_rd("R1 pending", 8'h08, 32'h0);
    chk_rd("R1 ctrl ch1", a_ctrl(1), 32'h0);
    chk_rd("R1 cnt ch6", a_cnt(6), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 address map
    wr(a_cmp(3), 32'h5A);
    chk_rd("R2 cmp ch3", a_cmp(3), 32'h5A);
    wr(a_clk(3), 32'h11);
    chk_rd("R2 clk ch3", a_clk(3), 32'h11);
    wr(8'h00, 32'h3F);
    chk_rd("R2 mask", 8'h00, 32'h3F);
    wr(8'h00, 32'h0);
    chk_rd("R2 unmapped block", 8'h7C, 32'h0);

    // R3 counting, hold, ignored counter write
    wr(a_ctrl(2), 32'h31);
    waitn(10);
    chk_rd("R3 count", a_cnt(2), 32'd10);
    wr(a_cnt(2), 32'h77);
    chk_rd("R3 cnt write ignored", a_cnt(2), 32'd11);
    wr(a_ctrl(2), 32'h30);
    waitn(5);
    chk_rd("R3 hold when disabled", a_cnt(2), 32'd12);

    // R4 source and divider
    wr(a_clk(2), 32'h10);
    wr(a_ctrl(2), 32'h33);
    waitn(4);
    chk_rd("R4 slow source ignores fast", a_cnt(2), 32'd0);
    fast_tick = 1'b0; slow_tick = 1'b1;
    waitn(5);
    chk_rd("R4 slow source counts", a_cnt(2), 32'd5);
    wr(a_clk(2), 32'h11);
    waitn(6);
    chk_rd("R4 divide by two", a_cnt(2), 32'd9);
    wr(a_ctrl(2), 32'h0);
    fast_tick = 1'b1; slow_tick = 1'b0;

    // R5 one-shot
    wr(a_cmp(1), 32'd5);
    wr(a_ctrl(1), 32'h03);
    waitn(4);
    chk_rd("R5 no event early", 8'h08, 32'h0);
    waitn(1);
    chk_rd("R5 pending on hit", 8'h08, 32'h1);
    chk_rd("R5 enable cleared", a_ctrl(1), 32'h0);
    waitn(3);
    chk_rd("R5 counter holds", a_cnt(1), 32'd5);

    // R10 mask and combined line
    chk("R10 masked pending keeps irq low", 32'(irq), 32'h0);
    wr(8'h00, 32'h01);
    chk("R10 irq on unmask", 32'(irq), 32'h1);

    // R9 acknowledge
    wr(8'h08, 32'h02);
    chk_rd("R9 other bit no effect", 8'h08, 32'h1);
    wr(8'h08, 32'h01);
    chk_rd("R9 ack clears", 8'h08, 32'h0);
    chk("R10 irq drops", 32'(irq), 32'h0);
    wr(8'h00, 32'h0);

    // R6 repeat
    wr(a_cmp(4), 32'd3);
    wr(a_ctrl(4), 32'h13);
    waitn(3);
    chk_rd("R6 pending", 8'h08, 32'h08);
    chk_rd("R6 reload", a_cnt(4), 32'd0);
    wr(8'h08, 32'h08);
    waitn(1);
    chk_rd("R6 mid period", a_cnt(4), 32'd2);
    chk_rd("R6 no early event", 8'h08, 32'h0);
    waitn(1);
    chk_rd("R6 second event", 8'h08, 32'h08);
    wr(a_ctrl(4), 32'h0);
    wr(8'h08, 32'h3F);

    // R7 free-run wrap
    wr(a_cmp(5), 32'd4);
    wr(a_ctrl(5), 32'h33);
    waitn(255);
    chk_rd("R7 top value", a_cnt(5), 32'hFF);
    waitn(1);
    chk_rd("R7 wrap", a_cnt(5), 32'h0);
    chk_rd("R7 no pending", 8'h08, 32'h0);

    // R8 clear while running
    waitn(6);
    wr(a_ctrl(5), 32'h33);
    chk_rd("R8 cleared", a_cnt(5), 32'h0);
    chk_rd("R8 clear reads 0", a_ctrl(5), 32'h31);
    waitn(2);
    chk_rd("R8 restart", a_cnt(5), 32'd2);

    // R9 event and ack in the same cycle
    wr(a_cmp(1), 32'd2);
    wr(a_ctrl(1), 32'h03);
    waitn(1);
    wr(8'h08, 32'h01);
    chk_rd("R9 event beats ack", 8'h08, 32'h01);

    // R4 R5 random one-shot timing
    for (int t = 0; t < 24; t++) begin
      int ch, cmp, div, dly;
      ch  = 1 + int'($urandom % 6);
      cmp = 1 + int'($urandom % 30);
      div = int'($urandom % 2);
      dly = hit_delay(cmp, div);
      wr(8'h08, 32'h3F);
      wr(a_clk(ch), 32'(div));
      wr(a_cmp(ch), 32'(cmp));
      wr(a_ctrl(ch), 32'h03);
      waitn(dly - 1);
      rd(8'h08, d);
      chk("R4 random no early hit", 32'(d[ch-1]), 32'h0);
      waitn(1);
      rd(8'h08, d);
      chk("R5 random hit", 32'(d[ch-1]), 32'h1);
      chk_rd("R5 random counter", a_cnt(ch), 32'(cmp));
      chk_rd("R5 random stopped", a_ctrl(ch), 32'h0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule